// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when a backup cell is tested under load and keeps a latched low-battery warning. While system power is good it runs one test after each power-up, after a short settling delay, and then repeats tests at a long interval. Each test raises a load-enable output for a fixed number of slow ticks. During that pulse it watches a comparator flag that reports "battery below trip". If that flag is seen high at any point in the pulse, the warning is set.

Once the warning is set, tests repeat at a short interval so that a swapped cell is noticed quickly. A passing retest only clears the warning in two cases. The first is after the battery-present input has been low for at least a minimum number of ticks and has then returned. The second is when the test is the first one after a power-up. All intervals are parameters counted in ticks of a slow enable strobe, so a real day-long period and a short test setting use the same logic. The warning output is an active-high pull-down enable for an external open-drain pin.

Top module: `batt_test_sched`

## Requirements
- R1: While and after reset, with power not good, `load_en` and `warn_drive` are both 0.
- R2: No test runs while `pwr_ok` is 0. After `pwr_ok` rises, the first test starts once RECOVER_TICKS ticks have passed, whatever the warning state.
- R3: A test holds `load_en` at 1 for exactly PULSE_TICKS ticks.
- R4: With the warning clear, the next test starts NORM_TICKS ticks after the previous pulse ends.
- R5: If `batt_low` is 1 in any clock cycle of a pulse, including its last cycle, `warn_drive` is 1 from the end of that pulse.
- R6: With the warning set, the next test starts WARN_TICKS ticks after the previous pulse ends.
- R7: A passing test leaves a set warning in place unless a clear has been armed (R8) or the test is the first after a power-up (R10).
- R8: A detach arms the clear when `batt_here` stays 0 for at least DETACH_TICKS ticks, counted from its falling edge, and then returns to 1. The next passing test then clears the warning and the long interval resumes. A shorter detach arms nothing.
- R9: When `pwr_ok` drops, `load_en` goes to 0 at the next clock edge. The interrupted test gives no verdict, and the warning keeps its value.
- R10: The first test after a power-up clears a set warning if it passes, with no detach needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow timing strobe, one clock wide; all intervals count these |
| pwr_ok | input | 1 | System supply within tolerance |
| batt_low | input | 1 | Comparator: loaded battery below trip point |
| batt_here | input | 1 | Battery attached |
| load_en | output | 1 | Connects the test load to the battery |
| warn_drive | output | 1 | 1 = pull the open-drain warning pin low |

## Verification
A wrong interval counter or sequencer state shows up as a shift in when `load_en` rises or falls. The reference model catches that within one tick of the expected edge. A wrong failure record or arming state shows up at `warn_drive` at the first test end after the fault, which is at most one long interval later. Because of this, the stimulus places detaches and failing readings close to test boundaries, so that every latched state is forced to appear at a pulse end soon after it is created.

// File: rtl/bts_pkg.sv
package bts_pkg;
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_WAIT = 2'd1,
      PH_TEST = 2'd2
   } bts_phase_e;
endpackage

// File: rtl/bts_interval_ctr.sv
module bts_interval_ctr #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);
   localparam logic [CW-1:0] ONE = CW'(1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (tick && cnt_q != '0) cnt_q <= cnt_q - ONE;
   end

   // fires on the tick that ends the programmed span
   assign expire = tick && (cnt_q == ONE);
endmodule

// File: rtl/bts_detach_mon.sv
module bts_detach_mon #(
   parameter int unsigned MIN_TICKS = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic present,
   output logic arm_pulse
);
   localparam int unsigned DW = $clog2(MIN_TICKS + 1);
   localparam logic [DW-1:0] LIMIT = DW'(MIN_TICKS);
   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] away_q;
   logic          present_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         away_q    <= '0;
         present_q <= 1'b1;
      end else begin
         present_q <= present;
         if (present)                      away_q <= '0;
         else if (tick && away_q < LIMIT)  away_q <= away_q + ONE;
      end
   end

   // reattach after a long enough absence
   assign arm_pulse = present && !present_q && (away_q >= LIMIT);
endmodule

// File: rtl/bts_fail_acc.sv
module bts_fail_acc (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic active,
   input  logic cmp_low,
   output logic bad
);
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_q <= 1'b0;
      else if (clear)              seen_q <= 1'b0;
      else if (active && cmp_low)  seen_q <= 1'b1;
   end

   // verdict includes the reading of the final cycle
   assign bad = seen_q || cmp_low;
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
   import bts_pkg::*;
#(
   parameter int unsigned NORM_TICKS    = 86400,
   parameter int unsigned WARN_TICKS    = 5,
   parameter int unsigned PULSE_TICKS   = 1,
   parameter int unsigned DETACH_TICKS  = 7,
   parameter int unsigned RECOVER_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pwr_ok,
   input  logic batt_low,
   input  logic batt_here,
   output logic load_en,
   output logic warn_drive
);
   localparam int unsigned MAX_A = (NORM_TICKS > WARN_TICKS) ? NORM_TICKS : WARN_TICKS;
   localparam int unsigned MAX_B = (PULSE_TICKS > RECOVER_TICKS) ? PULSE_TICKS : RECOVER_TICKS;
   localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CW    = $clog2(MAX_T + 1);
   localparam logic [CW-1:0] V_NORM  = CW'(NORM_TICKS);
   localparam logic [CW-1:0] V_WARN  = CW'(WARN_TICKS);
   localparam logic [CW-1:0] V_PULSE = CW'(PULSE_TICKS);
   localparam logic [CW-1:0] V_REC   = CW'(RECOVER_TICKS);

   generate
      if (NORM_TICKS < 1 || WARN_TICKS < 1 || PULSE_TICKS < 1 ||
          DETACH_TICKS < 1 || RECOVER_TICKS < 1) begin : g_bad_cfg
         $error("batt_test_sched: every interval must be at least one tick");
      end
   endgenerate

   bts_phase_e    phase_q, phase_d;
   logic          warn_q, warn_d;
   logic          armed_q, armed_d;
   logic          first_q, first_d;
   logic          ctr_load, ctr_expire;
   logic [CW-1:0] ctr_val;
   logic          acc_clear, verdict_bad, arm_pulse, test_done;

   bts_interval_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(ctr_load), .load_val(ctr_val), .expire(ctr_expire)
   );

   bts_detach_mon #(.MIN_TICKS(DETACH_TICKS)) u_detach (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .present(batt_here), .arm_pulse(arm_pulse)
   );

   bts_fail_acc u_acc (
      .clk(clk), .rst_n(rst_n), .clear(acc_clear),
      .active(phase_q == PH_TEST), .cmp_low(batt_low), .bad(verdict_bad)
   );

   always_comb begin
      phase_d   = phase_q;
      warn_d    = warn_q;
      first_d   = first_q;
      ctr_load  = 1'b0;
      ctr_val   = '0;
      acc_clear = 1'b0;
      test_done = 1'b0;
      if (!pwr_ok) begin
         phase_d   = PH_OFF;
         first_d   = 1'b0;
         ctr_load  = 1'b1;
         acc_clear = 1'b1;
      end else begin
         case (phase_q)
            PH_OFF: begin
               phase_d  = PH_WAIT;
               ctr_load = 1'b1;
               ctr_val  = V_REC;
               first_d  = 1'b1;
            end
            PH_WAIT: begin
               if (ctr_expire) begin
                  phase_d   = PH_TEST;
                  ctr_load  = 1'b1;
                  ctr_val   = V_PULSE;
                  acc_clear = 1'b1;
               end
            end
            PH_TEST: begin
               if (ctr_expire) begin
                  test_done = 1'b1;
                  phase_d   = PH_WAIT;
                  first_d   = 1'b0;
                  ctr_load  = 1'b1;
                  acc_clear = 1'b1;
                  if (verdict_bad)            warn_d = 1'b1;
                  else if (armed_q || first_q) warn_d = 1'b0;
                  ctr_val = warn_d ? V_WARN : V_NORM;
               end
            end
            default: phase_d = PH_OFF;
         endcase
      end
      armed_d = arm_pulse || (armed_q && !test_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         warn_q  <= 1'b0;
         armed_q <= 1'b0;
         first_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         warn_q  <= warn_d;
         armed_q <= armed_d;
         first_q <= first_d;
      end
   end

   assign load_en    = (phase_q == PH_TEST);
   assign warn_drive = warn_q;
endmodule

// File: rtl/batt_test_sched_chk.sv
module batt_test_sched_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic pwr_ok,
   input logic load_en,
   input logic warn_drive
);
   // R9
   load_off_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> !load_en);

   // R2
   start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_en) |-> ($past(tick) && $past(pwr_ok)));

   // R3
   end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_en) |-> ($past(tick) || !$past(pwr_ok)));

   // R5
   warn_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn_drive) |-> $fell(load_en));

   // R8
   warn_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(warn_drive) |-> $fell(load_en));
endmodule

bind batt_test_sched batt_test_sched_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok),
   .load_en(load_en), .warn_drive(warn_drive)
);

// File: tb/batt_test_sched_bench.sv
module batt_test_sched_bench;
   localparam int NORM = 20, WARN = 5, PULSE = 2, DET = 7, REC = 3;

   logic clk = 0, rst_n = 0, tick = 0, pwr_ok = 0, batt_low = 0, batt_here = 1;
   logic load_en, warn_drive;
   int checks = 0, errors = 0, tc = 0;
   bit done = 0;

   batt_test_sched #(.NORM_TICKS(NORM), .WARN_TICKS(WARN), .PULSE_TICKS(PULSE),
      .DETACH_TICKS(DET), .RECOVER_TICKS(REC)) u_batt_test_sched (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok), .batt_low(batt_low),
      .batt_here(batt_here), .load_en(load_en), .warn_drive(warn_drive));

   always #4 clk = ~clk;

   initial forever begin
      @(negedge clk);
      tick = ~tick;
   end

   // behavioural reference: 0 off, 1 waiting, 2 testing
   int m_ph = 0, m_cnt = 0, m_det = 0;
   bit m_warn = 0, m_arm = 0, m_first = 0, m_fail = 0, m_prev_here = 1;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_det = 0; m_warn = 0; m_arm = 0;
         m_first = 0; m_fail = 0; m_prev_here = 1;
      end else begin
         bit arm_now, finished, expire, acc;
         if (tick) tc = tc + 1;
         arm_now = batt_here && !m_prev_here && m_det >= DET;
         if (batt_here) m_det = 0;
         else if (tick && m_det < DET) m_det = m_det + 1;
         m_prev_here = batt_here;
         finished = 0;
         expire = tick && m_cnt == 1;
         if (!pwr_ok) begin
            m_ph = 0; m_cnt = 0; m_fail = 0; m_first = 0;
         end else if (m_ph == 0) begin
            m_ph = 1; m_cnt = REC; m_first = 1;
         end else if (m_ph == 1) begin
            if (expire) begin m_ph = 2; m_cnt = PULSE; m_fail = 0; end
            else if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
         end else begin
            acc = m_fail || batt_low;
            if (expire) begin
               finished = 1;
               if (acc) m_warn = 1;
               else if (m_arm || m_first) m_warn = 0;
               m_first = 0; m_ph = 1; m_fail = 0;
               m_cnt = m_warn ? WARN : NORM;
            end else begin
               m_fail = acc;
               if (tick && m_cnt != 0) m_cnt = m_cnt - 1;
            end
         end
         m_arm = arm_now || (m_arm && !finished);
      end
   end

   always @(negedge clk) if (rst_n && !done) begin
      checks++;
      if (load_en !== (m_ph == 2) || warn_drive !== m_warn) begin
         errors++;
         $display("FAIL R2/R3/R4/R6 model: load_en=%0b warn=%0b expected %0b %0b",
                  load_en, warn_drive, (m_ph == 2), m_warn);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_load(input logic lvl, output int at);
      @(negedge clk);
      while (load_en !== lvl) @(negedge clk);
      at = tc;
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int r, f, p0, highs;
      repeat (4) @(negedge clk);
      chk(load_en === 0 && warn_drive === 0, "R1 in reset", {load_en, warn_drive}, 0);
      rst_n = 1;
      repeat (6) @(negedge clk);
      chk(load_en === 0 && warn_drive === 0, "R1 after reset", {load_en, warn_drive}, 0);
      chk(load_en === 0, "R2 power off idle", load_en, 0);
      p0 = tc;
      pwr_ok = 1;
      wait_load(1, r);
      chk(r - p0 == REC || r - p0 == REC + 1, "R2 recovery delay", r - p0, REC);
      wait_load(0, f);
      chk(f - r == PULSE, "R3 pulse width", f - r, PULSE);
      chk(warn_drive === 0, "R3 good battery", warn_drive, 0);
      wait_load(1, r);
      chk(r - f == NORM, "R4 normal interval", r - f, NORM);
      @(negedge clk); batt_low = 1;
      @(negedge clk); batt_low = 0;
      wait_load(0, f);
      chk(warn_drive === 1, "R5 brief low in pulse", warn_drive, 1);
      wait_load(1, r);
      chk(r - f == WARN, "R6 warn interval", r - f, WARN);
      wait_load(0, f);
      chk(warn_drive === 1, "R7 pass without detach", warn_drive, 1);
      batt_here = 0;
      repeat (6) @(negedge clk);
      batt_here = 1;
      wait_load(1, r);
      wait_load(0, f);
      chk(warn_drive === 1, "R8 short detach", warn_drive, 1);
      batt_here = 0; batt_low = 1;
      repeat (16) @(negedge clk);
      batt_here = 1; batt_low = 0;
      wait_load(1, r);
      wait_load(0, f);
      chk(warn_drive === 0, "R8 long detach clears", warn_drive, 0);
      wait_load(1, r);
      chk(r - f == NORM, "R8 normal rate resumes", r - f, NORM);
      wait_load(0, f);
      batt_low = 1;
      wait_load(1, r);
      repeat (3) @(negedge clk);
      wait_load(0, f);
      batt_low = 0;
      chk(warn_drive === 1, "R5 low through pulse end", warn_drive, 1);
      wait_load(1, r);
      @(negedge clk); pwr_ok = 0;
      @(negedge clk);
      chk(load_en === 0, "R9 load drops", load_en, 0);
      highs = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (load_en) highs++;
      end
      chk(highs == 0, "R2 no test while off", highs, 0);
      chk(warn_drive === 1, "R9 warn kept", warn_drive, 1);
      pwr_ok = 1;
      wait_load(1, r);
      wait_load(0, f);
      chk(warn_drive === 0, "R10 power-up retest clears", warn_drive, 0);
      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule